// File: doc/BRIEF.md
# Timed Event Dispatcher

This block sits between an event source that has already parsed timed records out of memory and a real-time output engine. Each event it accepts (a channel selector, a timestamp, a sub-address and a data word) goes out as one write command on the command interface. After every write it holds the next event back until the target's status reports that it is no longer busy. Because of this handshake, a slow or stalled target never sees two commands overlap. Events leave in exactly the order they arrive, with none lost or repeated.

The block also holds the control state that software sees. Software programs a base address while the dispatcher is idle and then sets the enable bit. That raises a one-cycle start pulse for the memory fetcher and marks a run as in progress. The enable bit drops by itself once the event source delivers the end-of-sequence marker. Underflow and unreachable-destination reports from the target collect in a two-bit sticky error register. Software reads that register after the run ends, and the next start clears it.

Top module: `tevt_dispatch`

## Requirements
- R1: After reset the command is no-op (code 0), the run flag, the start pulse, the error register and the base address are all 0, and no event is accepted.
- R2: A control write (`cfg_sel`=1) with data bit 0 set, made while idle, raises `run_en_o` and a one-cycle `run_start_o` at the next clock edge. A control write with bit 0 clear does not start a run.
- R3: Each accepted event that is not the end marker produces exactly one cycle of command code 1 (write), in the cycle right after its acceptance. The command code is 0 (no-op) in every other cycle.
- R4: `ev_ready` is low during the write cycle. It stays low for each following cycle in which status bit 0 (busy) is sampled high, and for the first cycle in which busy is sampled low. It returns high one cycle after that, so a zero-length busy wait costs two cycles.
- R5: The channel, timestamp, sub-address and data of the writes equal those of the accepted events, in acceptance order, with none dropped or duplicated.
- R6: Status bit 1 sampled high in a busy-wait cycle sets error bit 0 (underflow). Status bit 2 sets error bit 1 (destination unreachable). Both bits hold until the next start.
- R7: An error does not stop the run: every remaining event up to the end marker is still written.
- R8: Accepting the end marker issues no write and clears `run_en_o` at the next edge.
- R9: Starting a run clears both error bits in the same edge that raises `run_en_o`.
- R10: A base write (`cfg_sel`=0) made while idle shows on `base_addr_o` at the next edge. A base write made while a run is active is ignored.
- R11: Control writes made during a run, with bit 0 either set or clear, neither stop the run nor pulse `run_start_o` again.
- R12: `ev_ready` is low whenever `run_en_o` is low.
- R13: With `FIELD_HOLD`=0 (default), the channel, timestamp, sub-address and data outputs read 0 in every no-op cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 base address, 1 control |
| cfg_wdata | input | BASE_W | Register write data; control uses bit 0 |
| base_addr_o | output | BASE_W | Programmed base address |
| run_en_o | output | 1 | Enable bit, high while a run is in progress |
| run_start_o | output | 1 | One-cycle pulse when a run starts |
| err_o | output | 2 | Sticky errors: bit 0 underflow, bit 1 unreachable |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event accepted when high together with ev_valid |
| ev_end | input | 1 | Presented item is the end-of-sequence marker |
| ev_chan | input | CHAN_W | Event channel selector |
| ev_time | input | TS_W | Event timestamp |
| ev_addr | input | ADDR_W | Event sub-address |
| ev_data | input | DATA_W | Event data |
| cmd_o | output | 2 | Command code: 0 no-op, 1 write |
| chan_o | output | CHAN_W | Channel select of the write |
| time_o | output | TS_W | Timestamp of the write |
| addr_o | output | ADDR_W | Sub-address of the write |
| data_o | output | DATA_W | Data of the write |
| tgt_status | input | 3 | Target status: bit 0 busy, bit 1 underflow, bit 2 unreachable |

## Verification
Register writes take effect at the edge that samples them, so the bench checks base, run flag, start pulse and cleared errors at the falling edge that follows. A write command appears one cycle after the acceptance edge. The busy window opens in the cycle after that, and `ev_ready` comes back two cycles after the last busy cycle. The bench keeps a per-write countdown of busy cycles and uses it to predict `ev_ready` at every falling edge. It drives status only inside that window and injects error flags on the final, non-busy sample, so the expected sticky error value at the end-of-run edge follows from which events were flagged.

// File: rtl/tevt_pkg.sv
package tevt_pkg;
   localparam int CMD_W    = 2;
   localparam int STAT_W   = 3;
   localparam int ERR_BITS = 2;

   localparam int ST_BUSY   = 0;
   localparam int ST_UFLOW  = 1;
   localparam int ST_UNREACH = 2;

   typedef enum logic [CMD_W-1:0] {
      CMD_NOP   = 2'd0,
      CMD_WRITE = 2'd1
   } cmd_e;

   typedef enum logic [1:0] {
      IS_READY = 2'd0,
      IS_ISSUE = 2'd1,
      IS_WAIT  = 2'd2
   } iss_state_e;
endpackage

// File: rtl/tevt_ctrl_regs.sv
module tevt_ctrl_regs #(
   parameter int BASE_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [BASE_W-1:0] cfg_wdata,
   input  logic              run_done,
   output logic [BASE_W-1:0] base_addr,
   output logic              run_en,
   output logic              run_start,
   output logic              err_clr
);
   logic [BASE_W-1:0] base_q;
   logic              run_q;
   logic              start_q;
   logic              start_req;
   logic              base_wr;

   // a start request only counts while no run is in flight
   assign start_req = cfg_we && cfg_sel && cfg_wdata[0] && !run_q;
   assign base_wr   = cfg_we && !cfg_sel && !run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         run_q   <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= start_req;
         if (base_wr) begin
            base_q <= cfg_wdata;
         end
         if (start_req) begin
            run_q <= 1'b1;
         end else if (run_done) begin
            run_q <= 1'b0;
         end
      end
   end

   assign base_addr = base_q;
   assign run_en    = run_q;
   assign run_start = start_q;
   assign err_clr   = start_req;
endmodule

// File: rtl/tevt_issue.sv
module tevt_issue
   import tevt_pkg::*;
#(
   parameter int CHAN_W     = 24,
   parameter int TS_W       = 64,
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter bit FIELD_HOLD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              ev_valid,
   input  logic              ev_end,
   input  logic [CHAN_W-1:0] ev_chan,
   input  logic [TS_W-1:0]   ev_time,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [DATA_W-1:0] ev_data,
   input  logic              tgt_busy,
   output logic              ev_ready,
   output logic              run_done,
   output logic              waiting,
   output logic [CMD_W-1:0]  cmd,
   output logic [CHAN_W-1:0] chan,
   output logic [TS_W-1:0]   tstamp,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);
   localparam int FLD_W = CHAN_W + TS_W + ADDR_W + DATA_W;

   iss_state_e       state_q, state_d;
   cmd_e             cmd_q;
   logic             accept;
   logic             launch;
   logic [FLD_W-1:0] fld_in;
   logic [FLD_W-1:0] fld_q;

   assign ev_ready = run_en && (state_q == IS_READY);
   assign accept   = ev_valid && ev_ready;
   assign run_done = accept && ev_end;
   assign launch   = accept && !ev_end;
   assign waiting  = (state_q == IS_WAIT);
   assign fld_in   = {ev_chan, ev_time, ev_addr, ev_data};

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         IS_READY: if (launch)    state_d = IS_ISSUE;
         IS_ISSUE:                state_d = IS_WAIT;
         IS_WAIT:  if (!tgt_busy) state_d = IS_READY;
         default:                 state_d = IS_READY;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= IS_READY;
         cmd_q   <= CMD_NOP;
      end else begin
         state_q <= state_d;
         cmd_q   <= launch ? CMD_WRITE : CMD_NOP;
      end
   end

   // field register variant: keep the last write, or blank between writes
   if (FIELD_HOLD) begin : g_hold
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fld_q <= '0;
         end else if (launch) begin
            fld_q <= fld_in;
         end
      end
   end else begin : g_blank
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fld_q <= '0;
         end else begin
            fld_q <= launch ? fld_in : '0;
         end
      end
   end

   assign cmd                         = cmd_q;
   assign {chan, tstamp, addr, data}  = fld_q;
endmodule

// File: rtl/tevt_err_track.sv
module tevt_err_track
   import tevt_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                capture,
   input  logic [ERR_BITS-1:0] flags,
   output logic [ERR_BITS-1:0] err
);
   for (genvar i = 0; i < ERR_BITS; i++) begin : g_bit
      logic sticky_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sticky_q <= 1'b0;
         end else if (clr) begin
            sticky_q <= 1'b0;
         end else if (capture && flags[i]) begin
            sticky_q <= 1'b1;
         end
      end
      assign err[i] = sticky_q;
   end
endmodule

// File: rtl/tevt_dispatch.sv
module tevt_dispatch
   import tevt_pkg::*;
#(
   parameter int CHAN_W     = 24,
   parameter int TS_W       = 64,
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int BASE_W     = 32,
   parameter bit FIELD_HOLD = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic                cfg_sel,
   input  logic [BASE_W-1:0]   cfg_wdata,
   output logic [BASE_W-1:0]   base_addr_o,
   output logic                run_en_o,
   output logic                run_start_o,
   output logic [ERR_BITS-1:0] err_o,
   input  logic                ev_valid,
   output logic                ev_ready,
   input  logic                ev_end,
   input  logic [CHAN_W-1:0]   ev_chan,
   input  logic [TS_W-1:0]     ev_time,
   input  logic [ADDR_W-1:0]   ev_addr,
   input  logic [DATA_W-1:0]   ev_data,
   output logic [CMD_W-1:0]    cmd_o,
   output logic [CHAN_W-1:0]   chan_o,
   output logic [TS_W-1:0]     time_o,
   output logic [ADDR_W-1:0]   addr_o,
   output logic [DATA_W-1:0]   data_o,
   input  logic [STAT_W-1:0]   tgt_status
);
   if (CHAN_W < 1 || TS_W < 1 || ADDR_W < 1 || DATA_W < 1) begin : g_bad_field
      $error("tevt_dispatch: every field width must be at least 1");
   end
   if (BASE_W < 1) begin : g_bad_base
      $error("tevt_dispatch: BASE_W must be at least 1");
   end

   logic run_en;
   logic run_done;
   logic err_clr;
   logic waiting;

   tevt_ctrl_regs #(.BASE_W(BASE_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .run_done  (run_done),
      .base_addr (base_addr_o),
      .run_en    (run_en),
      .run_start (run_start_o),
      .err_clr   (err_clr)
   );

   tevt_issue #(
      .CHAN_W     (CHAN_W),
      .TS_W       (TS_W),
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .FIELD_HOLD (FIELD_HOLD)
   ) u_issue (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .ev_valid (ev_valid),
      .ev_end   (ev_end),
      .ev_chan  (ev_chan),
      .ev_time  (ev_time),
      .ev_addr  (ev_addr),
      .ev_data  (ev_data),
      .tgt_busy (tgt_status[ST_BUSY]),
      .ev_ready (ev_ready),
      .run_done (run_done),
      .waiting  (waiting),
      .cmd      (cmd_o),
      .chan     (chan_o),
      .tstamp   (time_o),
      .addr     (addr_o),
      .data     (data_o)
   );

   tevt_err_track u_err (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (err_clr),
      .capture (waiting),
      .flags   (tgt_status[ST_UFLOW +: ERR_BITS]),
      .err     (err_o)
   );

   assign run_en_o = run_en;
endmodule

// File: rtl/tevt_dispatch_chk.sv
module tevt_dispatch_chk
   import tevt_pkg::*;
#(
   parameter int CHAN_W     = 24,
   parameter int TS_W       = 64,
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int BASE_W     = 32,
   parameter bit FIELD_HOLD = 1'b0
) (
   input logic                clk,
   input logic                rst_n,
   input logic [BASE_W-1:0]   base_addr_o,
   input logic                run_en_o,
   input logic                run_start_o,
   input logic [ERR_BITS-1:0] err_o,
   input logic                ev_valid,
   input logic                ev_ready,
   input logic                ev_end,
   input logic [CMD_W-1:0]    cmd_o,
   input logic [CHAN_W-1:0]   chan_o,
   input logic [TS_W-1:0]     time_o,
   input logic [ADDR_W-1:0]   addr_o,
   input logic [DATA_W-1:0]   data_o,
   input logic [STAT_W-1:0]   tgt_status
);
   AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_WRITE) |=> (cmd_o == CMD_NOP)); // R3
   AST_WRITE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_ready && !ev_end) |=> (cmd_o == CMD_WRITE)); // R3
   AST_NOT_READY_AT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_WRITE) |-> !ev_ready); // R4
   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en_o && !ev_ready && cmd_o == CMD_NOP && tgt_status[ST_BUSY]) |=> !ev_ready); // R4
   AST_ERR0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_o[0]) |-> run_start_o); // R6
   AST_ERR1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_o[1]) |-> run_start_o); // R6
   AST_END_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_ready && ev_end) |=> !run_en_o); // R8
   AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      run_start_o |-> (run_en_o && err_o == '0)); // R9
   AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en_o && $past(run_en_o)) |-> $stable(base_addr_o)); // R10
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en_o && $past(run_en_o)) |-> !run_start_o); // R11
   AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en_o |-> !ev_ready); // R12

   if (!FIELD_HOLD) begin : g_blank_chk
      AST_FIELDS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_o == CMD_NOP) |-> (chan_o == '0 && time_o == '0 && addr_o == '0 && data_o == '0)); // R13
   end
endmodule

bind tevt_dispatch tevt_dispatch_chk #(
   .CHAN_W     (CHAN_W),
   .TS_W       (TS_W),
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .BASE_W     (BASE_W),
   .FIELD_HOLD (FIELD_HOLD)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .base_addr_o (base_addr_o),
   .run_en_o    (run_en_o),
   .run_start_o (run_start_o),
   .err_o       (err_o),
   .ev_valid    (ev_valid),
   .ev_ready    (ev_ready),
   .ev_end      (ev_end),
   .cmd_o       (cmd_o),
   .chan_o      (chan_o),
   .time_o      (time_o),
   .addr_o      (addr_o),
   .data_o      (data_o),
   .tgt_status  (tgt_status)
);

// File: tb/sim_tevt_dispatch.sv
`timescale 1ns/1ps
module sim_tevt_dispatch;
   localparam int CHAN_W = 16;
   localparam int TS_W   = 32;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam int BASE_W = 16;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst_n;
   logic              cfg_we, cfg_sel;
   logic [BASE_W-1:0] cfg_wdata;
   logic [BASE_W-1:0] base_addr_o;
   logic              run_en_o, run_start_o;
   logic [1:0]        err_o;
   logic              ev_valid, ev_ready, ev_end;
   logic [CHAN_W-1:0] ev_chan;
   logic [TS_W-1:0]   ev_time;
   logic [ADDR_W-1:0] ev_addr;
   logic [DATA_W-1:0] ev_data;
   logic [1:0]        cmd_o;
   logic [CHAN_W-1:0] chan_o;
   logic [TS_W-1:0]   time_o;
   logic [ADDR_W-1:0] addr_o;
   logic [DATA_W-1:0] data_o;
   logic [2:0]        tgt_status;

   int checks = 0;
   int errors = 0;

   tevt_dispatch #(
      .CHAN_W(CHAN_W), .TS_W(TS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_W(BASE_W)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .base_addr_o(base_addr_o), .run_en_o(run_en_o), .run_start_o(run_start_o), .err_o(err_o),
      .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_end(ev_end), .ev_chan(ev_chan),
      .ev_time(ev_time), .ev_addr(ev_addr), .ev_data(ev_data), .cmd_o(cmd_o),
      .chan_o(chan_o), .time_o(time_o), .addr_o(addr_o), .data_o(data_o),
      .tgt_status(tgt_status)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [CHAN_W-1:0] f_chan(int r, int i);
      return CHAN_W'(r * 40 + i * 7 + 1);
   endfunction
   function automatic logic [TS_W-1:0] f_time(int r, int i);
      return TS_W'(r * 1000 + i * 16 + 3);
   endfunction
   function automatic logic [ADDR_W-1:0] f_addr(int r, int i);
      return ADDR_W'(r * 16 + i * 5);
   endfunction
   function automatic logic [DATA_W-1:0] f_data(int r, int i);
      return DATA_W'(r * 16777216 + i * 66051 + 5);
   endfunction
   function automatic int f_busy(int r, int i);
      return (i + r) % 5;
   endfunction

   task automatic run_seq(input int r, input int nev, input logic [BASE_W-1:0] base,
                          input int uf_at, input int ur_at, input int gap_mod, input bit poke);
      int  ev_idx = 0;
      int  wr_idx = 0;
      int  blk = 0;
      int  cyc = 0;
      int  cur_ev = 0;
      bit  acc_wr = 0;
      bit  acc_end = 0;
      bit  done = 0;
      bit  valid;
      logic [1:0] exp_err = 2'b00;

      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = base;
      @(negedge clk);
      chk(base_addr_o == base, "R10", "idle base write", 64'(base_addr_o), 64'(base));
      cfg_sel = 1'b1; cfg_wdata = 1;
      @(negedge clk);
      cfg_we = 1'b0;
      chk(run_en_o == 1'b1, "R2", "run flag after start", 64'(run_en_o), 64'd1);
      chk(run_start_o == 1'b1, "R2", "start pulse", 64'(run_start_o), 64'd1);
      chk(err_o == 2'b00, "R9", "errors cleared at start", 64'(err_o), 64'd0);

      while (!done && cyc < 600) begin
         if (cyc > 0) begin
            if (acc_wr) begin
               chk(cmd_o == 2'd1, "R3", "write code", 64'(cmd_o), 64'd1);
               chk(chan_o == f_chan(r, wr_idx), "R5", "channel", 64'(chan_o), 64'(f_chan(r, wr_idx)));
               chk(time_o == f_time(r, wr_idx), "R5", "timestamp", 64'(time_o), 64'(f_time(r, wr_idx)));
               chk(addr_o == f_addr(r, wr_idx), "R5", "sub-address", 64'(addr_o), 64'(f_addr(r, wr_idx)));
               chk(data_o == f_data(r, wr_idx), "R5", "data", 64'(data_o), 64'(f_data(r, wr_idx)));
               cur_ev = wr_idx;
               blk = f_busy(r, wr_idx) + 1;
               wr_idx++;
            end else begin
               chk(cmd_o == 2'd0, "R3", "no-op code", 64'(cmd_o), 64'd0);
               chk(data_o == '0 && chan_o == '0, "R13", "blank fields", 64'(data_o), 64'd0);
            end
            if (acc_end) begin
               chk(run_en_o == 1'b0, "R8", "run flag after end", 64'(run_en_o), 64'd0);
               chk(ev_ready == 1'b0, "R12", "ready while stopped", 64'(ev_ready), 64'd0);
               chk(err_o == exp_err, "R6", "sticky errors", 64'(err_o), 64'(exp_err));
               chk(wr_idx == nev, "R7", "writes in run", 64'(wr_idx), 64'(nev));
               done = 1;
            end
         end
         if (poke && cyc >= 3 && cyc <= 5) begin
            chk(base_addr_o == base, "R10", "base held in run", 64'(base_addr_o), 64'(base));
            chk(run_en_o == 1'b1, "R11", "run kept", 64'(run_en_o), 64'd1);
            chk(run_start_o == 1'b0, "R11", "no second start", 64'(run_start_o), 64'd0);
         end
         if (!done) begin
            tgt_status = 3'b000;
            if (!acc_wr && blk > 0) begin
               chk(ev_ready == 1'b0, "R4", "blocked in wait", 64'(ev_ready), 64'd0);
               if (blk > 1) begin
                  tgt_status[0] = 1'b1;
               end else begin
                  tgt_status[1] = (cur_ev == uf_at);
                  tgt_status[2] = (cur_ev == ur_at);
                  if (cur_ev == uf_at) exp_err[0] = 1'b1;
                  if (cur_ev == ur_at) exp_err[1] = 1'b1;
               end
               blk--;
            end else if (acc_wr) begin
               chk(ev_ready == 1'b0, "R4", "blocked in write cycle", 64'(ev_ready), 64'd0);
            end else begin
               chk(ev_ready == 1'b1, "R4", "ready after wait", 64'(ev_ready), 64'd1);
            end
            cfg_we = 1'b0;
            if (poke && cyc == 2) begin
               cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = ~base;
            end else if (poke && cyc == 3) begin
               cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 0;
            end else if (poke && cyc == 4) begin
               cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 1;
            end
            valid = (gap_mod == 0) || (((cyc + r) % gap_mod) != 0);
            ev_valid = valid;
            ev_end   = (ev_idx == nev);
            ev_chan  = f_chan(r, ev_idx);
            ev_time  = f_time(r, ev_idx);
            ev_addr  = f_addr(r, ev_idx);
            ev_data  = f_data(r, ev_idx);
            acc_wr  = valid && ev_ready && (ev_idx < nev);
            acc_end = valid && ev_ready && (ev_idx == nev);
            if (valid && ev_ready) ev_idx++;
            @(negedge clk);
         end
         cyc++;
      end
      ev_valid = 1'b0; ev_end = 1'b0; tgt_status = 3'b000; cfg_we = 1'b0;
      if (!done) chk(1'b0, "R8", "run never ended", 64'(wr_idx), 64'(nev));
   endtask

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
      ev_valid = 1'b0; ev_end = 1'b0; ev_chan = '0; ev_time = '0; ev_addr = '0; ev_data = '0;
      tgt_status = 3'b000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_o == 2'd0, "R1", "reset command", 64'(cmd_o), 64'd0);
      chk(run_en_o == 1'b0, "R1", "reset run flag", 64'(run_en_o), 64'd0);
      chk(run_start_o == 1'b0, "R1", "reset start", 64'(run_start_o), 64'd0);
      chk(err_o == 2'b00, "R1", "reset errors", 64'(err_o), 64'd0);
      chk(base_addr_o == '0, "R1", "reset base", 64'(base_addr_o), 64'd0);
      chk(ev_ready == 1'b0, "R1", "reset ready", 64'(ev_ready), 64'd0);

      ev_valid = 1'b1; ev_end = 1'b0; ev_data = 32'hDEAD_BEEF;
      cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         cfg_we = 1'b0;
         chk(ev_ready == 1'b0, "R12", "idle ready", 64'(ev_ready), 64'd0);
         chk(cmd_o == 2'd0, "R12", "idle command", 64'(cmd_o), 64'd0);
         chk(run_en_o == 1'b0, "R2", "clear bit does not start", 64'(run_en_o), 64'd0);
      end
      ev_valid = 1'b0;

      run_seq(1, 6, 16'h0100, -1, -1, 0, 1'b0);
      run_seq(2, 5, 16'h0200,  1, -1, 3, 1'b0);
      run_seq(3, 5, 16'h0300,  0,  3, 0, 1'b1);
      run_seq(4, 4, 16'h0040, -1,  2, 2, 1'b0);
      run_seq(5, 7, 16'h0777,  6,  6, 4, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule